// File: doc/BRIEF.md
# Delta Bit-Plane Block Decompressor

This block rebuilds 8-bit data words from a packed stream of bit-plane symbols. Compressed bytes arrive on a valid/ready input. They are appended, most significant bit first, to a left-aligned bit window. A symbol decoder inspects the top nine bits of the window, works out one delta plane from the prefix code, and returns the length it used so that the window can shift by that many bits. Each decoded symbol is the XOR difference to the plane recovered before it. The block XORs it back onto that plane, so the chain of planes is restored from the sign plane downwards.

A block covers eight words and has nine delta planes. When all nine planes are present, the block moves into a one-entry holding stage. The next block can then be decoded while the held one is turned back into words. The reverse stage reads bit k of every plane to form the 9-bit signed delta of word k. It adds that delta to a running word and sends out one word per accepted output cycle. The last word of a block becomes the starting value for the next block, and that value is zero after reset. Zero-run expansion of the original word stream is handled elsewhere.

Top module: `bpc_block_decoder`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the running word is 0.
- R2: The symbol "1" followed by 8 raw bits gives an XOR value equal to those bits. Each XOR value is combined by XOR with the previously recovered plane of the same block. For the first plane of a block, the previous plane is taken as zero.
- R3: The short codes decode as follows: "00000" is an XOR value of all ones; "00001" makes the recovered plane zero; "00010" + 3-bit p sets bits p and p+1; "00011" + 3-bit p sets only bit p.
- R4: "01" is one plane with a zero XOR value. "001" + 3-bit n stands for n+2 consecutive planes that all equal the previous plane.
- R5: The running word carries from one block to the next, so a block's first delta is taken against the last word of the previous block.
- R6: Deltas are 9-bit two's complement, and each output word is the running word plus the delta, truncated to 8 bits.
- R7: out_valid stays 0 until every plane of the first block has been decoded.
- R8: While out_valid is 1 and out_ready is 0, out_data holds its value and no word is lost. A sustained stall fills the window and drives in_ready low.
- R9: Input bytes are consumed most significant bit first, and symbols may straddle byte boundaries. A symbol is decoded only once at least 9 bits are in the window.
- R10: The planes of a block come in the order sign plane (delta bit 8) down to delta bit 0. Bit k of each plane belongs to word k of the block, and word 0 is emitted first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed byte offered |
| in_ready | output | 1 | Window has room for a byte |
| in_data | input | 8 | Compressed byte, MSB first |
| out_valid | output | 1 | Reconstructed word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 8 | Reconstructed word |

## Verification
The bench looks at several error-prone points:
- A zero run that spans most of a block. A decoder that writes only one plane for a run symbol would lose planes and emit a shifted block.
- Deltas whose 8-bit sum wraps, and a second block whose first delta depends on the carried word. A design that resets the base per block would emit words offset by the last word of the previous block.
- A stream cut one symbol short of a full block must produce no output. A sustained output stall must hold the data and close in_ready. Early valid, dropped words or an overrun window would each show up as mismatched words.

// File: rtl/bpc_block_decoder.sv
module bpc_block_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int WORDS  = 8;
  localparam int PLANES = 9;
  localparam int WINW   = 9;
  localparam int BUFW   = 24;
  localparam int CNTW   = $clog2(BUFW + 1);

  logic [BUFW-1:0] sbuf;
  logic [CNTW-1:0] cnt;
  logic [3:0]      idx;
  logic            asm_full;
  logic [WORDS-1:0] prev;
  logic [WORDS-1:0] asm_pl  [1:PLANES-1];
  logic [WORDS-1:0] hold_pl [1:PLANES-1];
  logic            hold_v;
  logic [2:0]      k;
  logic [7:0]      base;

  logic [WINW-1:0] win;
  logic [3:0]      len;
  logic [3:0]      nplanes;
  logic [WORDS-1:0] plane;
  logic            dec_go, in_fire, out_fire, hold_load;
  logic [3:0]      used;
  logic [CNTW-1:0] rem;
  logic [4:0]      idx_sum;
  logic [7:0]      delta;

  assign win       = sbuf[BUFW-1 -: WINW];
  assign in_ready  = (cnt <= CNTW'(BUFW - 8));
  assign in_fire   = in_valid && in_ready;
  assign dec_go    = !asm_full && (cnt >= CNTW'(WINW));
  assign out_valid = hold_v;
  assign out_fire  = hold_v && out_ready;
  assign hold_load = asm_full && (!hold_v || (out_fire && k == 3'd7));
  assign used      = dec_go ? len : 4'd0;
  assign rem       = cnt - CNTW'(used);
  assign idx_sum   = {1'b0, idx} + {1'b0, nplanes};

  always_comb begin
    len     = 4'd9;
    nplanes = 4'd1;
    plane   = prev ^ win[7:0];
    if (!win[8]) begin
      if (win[7]) begin
        len   = 4'd2;
        plane = prev;
      end else if (win[6]) begin
        len     = 4'd6;
        nplanes = {1'b0, win[5:3]} + 4'd2;
        plane   = prev;
      end else begin
        case (win[5:4])
          2'b00: begin len = 4'd5; plane = ~prev; end
          2'b01: begin len = 4'd5; plane = '0; end
          2'b10: begin len = 4'd8; plane = prev ^ (8'h03 << win[3:1]); end
          default: begin len = 4'd8; plane = prev ^ (8'h01 << win[3:1]); end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbuf <= '0;
      cnt  <= '0;
    end else begin
      sbuf <= (sbuf << used) | (in_fire ? ({in_data, 16'h0} >> rem) : '0);
      cnt  <= rem + (in_fire ? CNTW'(8) : '0);
    end
  end

  for (genvar j = 1; j < PLANES; j++) begin : g_asm
    always_ff @(posedge clk) begin
      if (!rst_n)
        asm_pl[j] <= '0;
      else if (dec_go && (4'(j) >= idx) && (5'(j) < idx_sum))
        asm_pl[j] <= plane;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_pl[j] <= '0;
      else if (hold_load)
        hold_pl[j] <= asm_pl[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      asm_full <= 1'b0;
      prev     <= '0;
    end else if (hold_load) begin
      idx      <= '0;
      asm_full <= 1'b0;
      prev     <= '0;
    end else if (dec_go) begin
      prev <= plane;
      if (idx_sum >= 5'(PLANES)) begin
        idx      <= 4'(PLANES);
        asm_full <= 1'b1;
      end else begin
        idx <= idx_sum[3:0];
      end
    end
  end

  for (genvar b = 0; b < 8; b++) begin : g_delta
    assign delta[b] = hold_pl[PLANES-1-b][k];
  end
  assign out_data = base + delta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      k      <= '0;
      base   <= '0;
    end else begin
      if (out_fire) begin
        base <= out_data;
        k    <= k + 3'd1;
      end
      if (out_fire && k == 3'd7)
        hold_v <= hold_load;
      else if (hold_load)
        hold_v <= 1'b1;
    end
  end
endmodule

module bpc_block_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [4:0] cnt,
  input logic [3:0] idx,
  input logic       asm_full
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r9_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd24);
  a_r4_plane_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 4'd9);
  a_r7_full_means_all_planes: assert property (@(posedge clk) disable iff (!rst_n)
    asm_full |-> idx == 4'd9);
endmodule

bind bpc_block_decoder bpc_block_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .cnt(cnt), .idx(idx),
  .asm_full(asm_full)
);

// File: tb/tb_bpc_block_decoder.sv
module tb_bpc_block_decoder;
  logic clk = 0, rst_n = 0, in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0] in_data = 0, out_data;
  always #5 clk = ~clk;

  bpc_block_decoder dut (.*);

  int tests = 0, fails = 0;
  bit sbits [0:8191];
  int nb = 0;
  logic [7:0] exp_w [0:1023];
  int nexp = 0;
  logic [7:0] bm = 0;
  logic [31:0] lf = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] rnd();
    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
    return lf[7:0];
  endfunction

  task automatic do_reset();
    rst_n = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    nb = 0; nexp = 0; bm = 0;
  endtask

  task automatic put(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) begin sbits[nb] = v[i]; nb++; end
  endtask

  // R10: plane s=0 is delta bit 8; bit k of a plane is word k
  task automatic enc_block(input logic [63:0] ww, input bit raw_only);
    logic [8:0] d [8];
    logic [7:0] pl [9];
    logic [7:0] x, pv;
    int s, r, p;
    for (int kk = 0; kk < 8; kk++) begin
      d[kk] = {1'b0, ww[8*kk +: 8]} - {1'b0, bm};
      bm = ww[8*kk +: 8];
      exp_w[nexp] = bm; nexp++;
    end
    for (int si = 0; si < 9; si++)
      for (int kk = 0; kk < 8; kk++) pl[si][kk] = d[kk][8 - si];
    pv = 0; s = 0;
    while (s < 9) begin
      x = pl[s] ^ pv;
      r = 1;
      if (raw_only) begin put(1, 1); put(x, 8); end
      else if (x == 0) begin
        while (s + r < 9 && pl[s + r] == pl[s + r - 1]) r++;
        if (r == 1) put(1, 2);
        else begin put(1, 3); put(r - 2, 3); end
      end else if (x == 8'hFF) put(0, 5);
      else if (pl[s] == 0) put(1, 5);
      else if ($countones(x) == 1) begin
        p = 0; while (!x[p]) p++;
        put(3, 5); put(p, 3);
      end else begin
        p = 0; while (!x[p]) p++;
        if (p < 7 && x == (8'h03 << p)) begin put(2, 5); put(p, 3); end
        else begin put(1, 1); put(x, 8); end
      end
      s = s + r;
      pv = pl[s - 1];
    end
  endtask

  function automatic logic [7:0] byte_at(input int i);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[7 - j] = (8 * i + j < nb) ? sbits[8 * i + j] : 1'b0;
    return v;
  endfunction

  // mode 0: always ready, mode 1: ready two cycles out of three
  task automatic run_stream(input int mode, input int start, input string req);
    int sent, got, cyc, nbytes;
    bit pend;
    logic [7:0] held;
    sent = start; got = 0; cyc = 0; pend = 0; held = 0;
    nbytes = (nb + 7) / 8 + 2;
    while (got < nexp && cyc < 20000) begin
      @(negedge clk);
      in_valid = (sent < nbytes);
      in_data = byte_at(sent);
      out_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      #1;
      if (pend) begin
        check(out_valid && out_data == held, "R8 stall hold", out_data, held);
        pend = 0;
      end
      if (out_valid && out_ready) begin
        check(out_data == exp_w[got], req, out_data, exp_w[got]);
        got++;
      end else if (out_valid) begin
        pend = 1; held = out_data;
      end
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    @(negedge clk); in_valid = 0; out_ready = 0;
    check(got == nexp, {req, " word count"}, got, nexp);
  endtask

  task automatic t_reset();
    do_reset(); #1;
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);
    enc_block({8{8'h00}}, 0);
    run_stream(0, 0, "R1 zero base");
  endtask

  task automatic t_raw();
    do_reset();
    enc_block({8'h42, 8'h17, 8'hC3, 8'h05, 8'h99, 8'h3A, 8'hE0, 8'h71}, 1);
    enc_block({8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h80}, 1);
    run_stream(0, 0, "R2 R9 R10 raw chain");
  endtask

  task automatic t_codes();
    do_reset();
    enc_block({8'h08, 8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01}, 0);
    enc_block({8'h0C, 8'h0C, 8'h0C, 8'h0C, 8'h0C, 8'h08, 8'h08, 8'h08}, 0);
    enc_block({8'h14, 8'h14, 8'h14, 8'h14, 8'h10, 8'h0C, 8'h0C, 8'h0C}, 0);
    enc_block({8'h0A, 8'h0E, 8'h0F, 8'h0B, 8'h0C, 8'h0D, 8'h09, 8'h0B}, 0);
    run_stream(0, 0, "R3 short codes");
  endtask

  task automatic t_runs();
    do_reset();
    enc_block({8{8'h00}}, 0);
    enc_block({8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01}, 0);
    enc_block({8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01}, 0);
    run_stream(0, 0, "R4 zero runs");
  endtask

  task automatic t_carry();
    logic [63:0] w;
    do_reset();
    enc_block({8'h90, 8'h88, 8'h84, 8'h82, 8'h81, 8'h80, 8'h7F, 8'h7E}, 0);
    enc_block({8{8'h90}}, 0);
    for (int b = 0; b < 6; b++) begin
      for (int kk = 0; kk < 8; kk++) w[8*kk +: 8] = bm + (rnd() & 8'h07) - 8'h03;
      enc_block(w, 0);
    end
    run_stream(0, 0, "R5 base carry");
  endtask

  task automatic t_wrap();
    do_reset();
    enc_block({8'h02, 8'hFE, 8'h00, 8'h7F, 8'h80, 8'h01, 8'hFF, 8'h00}, 0);
    enc_block({8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF}, 0);
    run_stream(0, 0, "R6 wrap");
  endtask

  task automatic t_early();
    do_reset();
    enc_block({8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h0F, 8'hF0, 8'h11, 8'hEE}, 1);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); in_valid = 1; in_data = byte_at(i); out_ready = 1;
    end
    @(negedge clk); in_valid = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); #1;
      if (c == 29) check(!out_valid, "R7 no valid on partial block", out_valid, 0);
      else if (out_valid) check(0, "R7 early valid", out_valid, 0);
    end
    run_stream(0, 9, "R7 completion");
  endtask

  task automatic t_backpressure();
    int sent;
    logic [63:0] w;
    do_reset();
    for (int b = 0; b < 4; b++) begin
      for (int kk = 0; kk < 8; kk++) w[8*kk +: 8] = rnd();
      enc_block(w, b[0]);
    end
    sent = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      in_valid = 1; in_data = byte_at(sent); out_ready = 0;
      #1;
      if (in_ready) sent++;
    end
    @(negedge clk); in_valid = 0; #1;
    check(!in_ready, "R8 in_ready low under stall", in_ready, 0);
    check(out_valid && out_data == exp_w[0], "R8 first word held", out_data, exp_w[0]);
    run_stream(1, sent, "R8 backpressure");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_raw();
    t_codes();
    t_runs();
    t_carry();
    t_wrap();
    t_early();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule